// File: doc/BRIEF.md
# Programmable flag I/O port

This block is an eight-line general purpose flag port. Each line can be an output driven from a data register, or an input that raises a status flag. An input flag is captured either on a level or on an edge, and a per-line polarity bit chooses which level or which edge counts. Edge flags stay set until software clears them. The OR of the flags that are enabled in a mask register drives an interrupt line.

The port also serves the neighbouring peripherals. Lines 7 to 1 can each be handed to an SPI engine, which then drives that pin as a slave-select output. Line 0 can be given to the SPI engine as its slave-select input. Any input line can be routed as a shutdown request to an external PWM generator. A wake-up output is built only from gates, with no register, so a stopped clock does not prevent a wake-up.

Software reaches the port through a simple single-cycle write strobe with an address and data. Reads are combinational.

Top module: `gfp_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0, `irq_o` and `pwm_shutdown_o` are 0, and `spi_ss_in_n_o` is 1.
- R2: Address 0 sets the direction, with 1 meaning output, and an output line drives its bit of the output data. Writing to address 4 sets the output-data bits that are written as 1. Writing to address 5 clears the output-data bits that are written as 1. Both addresses read back the output data.
- R3: When the address 2 bit of a line is 0 (level mode), status bit i at address 6 equals the synchronized pin XOR the address 1 polarity bit. It follows the pin within three clock cycles.
- R4: When the address 2 bit of a line is 1 (edge mode) and its polarity bit is 0, a rising pin edge sets the status bit. The bit stays set after the pin returns low, and a falling edge does not set it.
- R5: In edge mode with the polarity bit set to 1, a falling edge sets the status bit and a rising edge does not.
- R6: Writing to address 6 clears the edge flags of the bits written as 1. Bits written as 0 keep their flags.
- R7: `irq_o` is high exactly when some status bit is set together with its mask bit at address 3.
- R8: `wake_o` responds to the raw pins with no clock edge. It is high when some input line with its mask bit set has pin XOR polarity equal to 1.
- R9: Setting bit i (i from 1 to 7) at address 7 makes line i an output that carries `spi_sel_n_i[i]`. Setting bit 0 passes the synchronized pin 0 to `spi_ss_in_n_o`. While bit 0 is clear, `spi_ss_in_n_o` is 1.
- R10: `pwm_shutdown_o` is the OR, over the input lines selected at address 8, of the synchronized pin XOR polarity.
- R11: A line that is driven as an output raises no status flag and no wake-up. Its flag starts to work once the line is an input again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| spi_sel_n_i | input | 7 | Slave selects from the SPI engine for lines 7..1 |
| spi_ss_in_n_o | output | 1 | Slave-select input to the SPI engine from line 0 |
| pwm_shutdown_o | output | 1 | Shutdown request to the PWM generator |
| wake_o | output | 1 | Unregistered wake-up request |
| irq_o | output | 1 | Interrupt request |

## Verification
A lost or corrupt edge-history bit appears at status address 6 as a missing or spurious flag. It shows within three cycles of the pin change that exposes it, and it then stays visible because edge flags are sticky. A flag register that holds a wrong value changes `irq_o` on the same cycle whenever that line is unmasked. A wrong direction or SPI-ownership bit shows at once on `pin_oe` and `pin_out`. It also silences or enables the flag, the wake-up and the shutdown paths of that line, which the directed cases observe after the synchronizer delay.

// File: rtl/gfp_pkg.sv
package gfp_pkg;
  localparam int unsigned GFP_AW = 4;

  typedef enum logic [GFP_AW-1:0] {
    A_DIR  = 4'd0,
    A_POL  = 4'd1,
    A_SENS = 4'd2,
    A_MASK = 4'd3,
    A_OSET = 4'd4,
    A_OCLR = 4'd5,
    A_STAT = 4'd6,
    A_SPI  = 4'd7,
    A_PWM  = 4'd8
  } gfp_addr_e;
endpackage

// File: rtl/gfp_sync.sv
module gfp_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gfp_regs.sv
module gfp_regs
  import gfp_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [GFP_AW-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      sens_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      spi_q,
  output logic [N-1:0]      pwm_q,
  output logic [N-1:0]      stat_clr_o
);
  logic [N-1:0] dir_d, pol_d, sens_d, mask_d, out_d, spi_d, pwm_d;
  logic         ld;

  assign ld = we_i;

  always_comb begin
    dir_d  = dir_q;
    pol_d  = pol_q;
    sens_d = sens_q;
    mask_d = mask_q;
    out_d  = out_q;
    spi_d  = spi_q;
    pwm_d  = pwm_q;
    stat_clr_o = '0;
    if (we_i) begin
      case (gfp_addr_e'(addr_i))
        A_DIR:  dir_d  = wdata_i;
        A_POL:  pol_d  = wdata_i;
        A_SENS: sens_d = wdata_i;
        A_MASK: mask_d = wdata_i;
        A_OSET: out_d  = out_q | wdata_i;
        A_OCLR: out_d  = out_q & ~wdata_i;
        A_STAT: stat_clr_o = wdata_i;
        A_SPI:  spi_d  = wdata_i;
        A_PWM:  pwm_d  = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      pol_q  <= '0;
      sens_q <= '0;
      mask_q <= '0;
      out_q  <= '0;
      spi_q  <= '0;
      pwm_q  <= '0;
    end else if (ld) begin
      dir_q  <= dir_d;
      pol_q  <= pol_d;
      sens_q <= sens_d;
      mask_q <= mask_d;
      out_q  <= out_d;
      spi_q  <= spi_d;
      pwm_q  <= pwm_d;
    end
  end

  always_comb begin
    case (gfp_addr_e'(addr_i))
      A_DIR:  rdata_o = dir_q;
      A_POL:  rdata_o = pol_q;
      A_SENS: rdata_o = sens_q;
      A_MASK: rdata_o = mask_q;
      A_OSET: rdata_o = out_q;
      A_OCLR: rdata_o = out_q;
      A_STAT: rdata_o = status_i;
      A_SPI:  rdata_o = spi_q;
      A_PWM:  rdata_o = pwm_q;
      default: rdata_o = '0;
    endcase
  end

  // R2: a set write drives every written-one bit high on the next cycle
  p_oset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_OSET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));

  // R2: a clear write drives every written-one bit low on the next cycle
  p_oclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_OCLR) |=> ((out_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/gfp_line_sense.sv
module gfp_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pol_i,
  input  logic edge_mode_i,
  input  logic enable_i,
  input  logic clr_i,
  output logic flag_o,
  output logic active_o
);
  logic prev_q;
  logic eflag_q, eflag_d;
  logic edge_hit;
  logic level_flag;

  assign edge_hit   = enable_i & (pol_i ? (prev_q & ~sync_i) : (~prev_q & sync_i));
  assign level_flag = enable_i & (sync_i ^ pol_i);
  assign active_o   = level_flag;

  always_comb begin
    if (edge_mode_i && enable_i) eflag_d = (eflag_q & ~clr_i) | edge_hit;
    else                         eflag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      eflag_q <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      eflag_q <= eflag_d;
    end
  end

  assign flag_o = edge_mode_i ? eflag_q : level_flag;

  // R4: an edge flag holds while no clear arrives
  p_edge_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eflag_q && edge_mode_i && enable_i && !clr_i) |=> eflag_q);

  // R4: an edge flag only rises when the pin changed in the selected direction
  p_edge_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eflag_q) |-> ($past(sync_i) != $past(prev_q)));

  // R6: a clear with no new edge empties the flag
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !edge_hit) |=> !eflag_q);

  // R3: level mode keeps the edge flag empty
  p_level_no_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode_i |=> !eflag_q);
endmodule

// File: rtl/gfp_port.sv
module gfp_port
  import gfp_pkg::*;
#(
  parameter int unsigned NLINES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [GFP_AW-1:0] reg_addr,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  input  logic [NLINES-1:1] spi_sel_n_i,
  output logic              spi_ss_in_n_o,
  output logic              pwm_shutdown_o,
  output logic              wake_o,
  output logic              irq_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [NLINES-1:0] pin_sync;
  logic [NLINES-1:0] dir_q, pol_q, sens_q, mask_q, out_q, spi_q, pwm_q;
  logic [NLINES-1:0] stat_clr, status, active;
  logic [NLINES-1:0] spi_own;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  gfp_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_i  (pin_in),
    .q_o  (pin_sync)
  );

  gfp_regs #(.N(NLINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .we_i      (reg_we),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .status_i  (status),
    .rdata_o   (reg_rdata),
    .dir_q     (dir_q),
    .pol_q     (pol_q),
    .sens_q    (sens_q),
    .mask_q    (mask_q),
    .out_q     (out_q),
    .spi_q     (spi_q),
    .pwm_q     (pwm_q),
    .stat_clr_o(stat_clr)
  );

  assign spi_own = {spi_q[NLINES-1:1], 1'b0};
  assign pin_oe  = dir_q | spi_own;
  assign pin_out = (spi_own & {spi_sel_n_i, 1'b0}) | (~spi_own & out_q);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    gfp_line_sense u_sense (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .sync_i     (pin_sync[i]),
      .pol_i      (pol_q[i]),
      .edge_mode_i(sens_q[i]),
      .enable_i   (~pin_oe[i]),
      .clr_i      (stat_clr[i]),
      .flag_o     (status[i]),
      .active_o   (active[i])
    );
  end

  assign irq_o          = |(status & mask_q);
  assign wake_o         = |(mask_q & ~pin_oe & (pin_in ^ pol_q));
  assign pwm_shutdown_o = |(pwm_q & active);
  assign spi_ss_in_n_o  = spi_q[0] ? pin_sync[0] : 1'b1;

  // R9: line 0 not handed to SPI keeps the select input idle
  p_ss_idle_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    !spi_q[0] |-> spi_ss_in_n_o);

  // R11: with every line driven, no wake-up can appear
  p_wake_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (&pin_oe) |-> !wake_o);

  // R7: no interrupt while the mask is empty
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/gfp_port_tb_top.sv
module gfp_port_tb_top;
  localparam time TCK = 8ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [7:1] spi_sel_n_i;
  logic       spi_ss_in_n_o, pwm_shutdown_o, wake_o, irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  gfp_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .spi_sel_n_i(spi_sel_n_i),
    .spi_ss_in_n_o(spi_ss_in_n_o), .pwm_shutdown_o(pwm_shutdown_o),
    .wake_o(wake_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], d);
      chk("R1 reg", {24'd0, d}, 32'd0);
    end
    chk("R1 oe", {24'd0, pin_oe}, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 pwm", {31'd0, pwm_shutdown_o}, 32'd0);
    chk("R1 ss", {31'd0, spi_ss_in_n_o}, 32'd1);
  endtask

  task automatic t_output;
    logic [7:0] d;
    wr(4'd0, 8'hFF);
    wr(4'd4, 8'hA5);
    #1 chk("R2 set", {24'd0, pin_out}, 32'hA5);
    wr(4'd5, 8'h05);
    #1 chk("R2 clr", {24'd0, pin_out}, 32'hA0);
    chk("R2 oe", {24'd0, pin_oe}, 32'hFF);
    rd(4'd4, d);
    chk("R2 readback", {24'd0, d}, 32'hA0);
    wr(4'd5, 8'hFF);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(4'd2, 8'h00);
    wr(4'd1, 8'h0F);
    set_pins(8'h33);
    rd(4'd6, d);
    chk("R3 level", {24'd0, d}, 32'h3C);
    set_pins(8'h00);
    rd(4'd6, d);
    chk("R3 level low", {24'd0, d}, 32'h0F);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    wr(4'd2, 8'hFF);
    set_pins(8'h01);
    rd(4'd6, d);
    chk("R4 rise", {24'd0, d}, 32'h01);
    set_pins(8'h00);
    rd(4'd6, d);
    chk("R4 sticky", {24'd0, d}, 32'h01);
    wr(4'd1, 8'h02);
    set_pins(8'h02);
    rd(4'd6, d);
    chk("R5 rise ignored", {24'd0, d}, 32'h01);
    set_pins(8'h00);
    rd(4'd6, d);
    chk("R5 fall", {24'd0, d}, 32'h03);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_w1c;
    logic [7:0] d;
    wr(4'd6, 8'h00);
    rd(4'd6, d);
    chk("R6 zero write", {24'd0, d}, 32'h03);
    wr(4'd6, 8'h01);
    rd(4'd6, d);
    chk("R6 clear one", {24'd0, d}, 32'h02);
    wr(4'd6, 8'h02);
    rd(4'd6, d);
    chk("R6 clear all", {24'd0, d}, 32'h00);
  endtask

  task automatic t_irq;
    set_pins(8'h04);
    chk("R7 masked", {31'd0, irq_o}, 32'd0);
    wr(4'd3, 8'h04);
    #1 chk("R7 unmasked", {31'd0, irq_o}, 32'd1);
    wr(4'd3, 8'h08);
    #1 chk("R7 other mask", {31'd0, irq_o}, 32'd0);
    wr(4'd3, 8'h00);
    set_pins(8'h00);
    wr(4'd6, 8'hFF);
  endtask

  task automatic t_wake;
    wr(4'd2, 8'h00);
    wr(4'd3, 8'h10);
    #1 chk("R8 idle", {31'd0, wake_o}, 32'd0);
    pin_in = 8'h10;
    #1 chk("R8 async high", {31'd0, wake_o}, 32'd1);
    pin_in = 8'h00;
    #1 chk("R8 async low", {31'd0, wake_o}, 32'd0);
    wr(4'd1, 8'h10);
    #1 chk("R8 active low", {31'd0, wake_o}, 32'd1);
    wr(4'd3, 8'h00);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_outdir;
    logic [7:0] d;
    wr(4'd0, 8'h20);
    wr(4'd3, 8'h20);
    set_pins(8'h20);
    rd(4'd6, d);
    chk("R11 no flag", {24'd0, d}, 32'h00);
    chk("R11 no wake", {31'd0, wake_o}, 32'd0);
    chk("R11 no irq", {31'd0, irq_o}, 32'd0);
    wr(4'd0, 8'h00);
    rd(4'd6, d);
    chk("R11 flag back", {24'd0, d}, 32'h20);
    wr(4'd3, 8'h00);
    set_pins(8'h00);
  endtask

  task automatic t_spi;
    spi_sel_n_i = 7'b0000010;
    wr(4'd7, 8'h06);
    #1 chk("R9 oe", {24'd0, pin_oe}, 32'h06);
    chk("R9 out", {24'd0, pin_out & 8'h06}, 32'h04);
    chk("R9 ss idle", {31'd0, spi_ss_in_n_o}, 32'd1);
    wr(4'd7, 8'h07);
    set_pins(8'h00);
    chk("R9 ss low", {31'd0, spi_ss_in_n_o}, 32'd0);
    set_pins(8'h01);
    chk("R9 ss high", {31'd0, spi_ss_in_n_o}, 32'd1);
    wr(4'd7, 8'h00);
    set_pins(8'h00);
    chk("R9 released", {31'd0, spi_ss_in_n_o}, 32'd1);
  endtask

  task automatic t_pwm;
    wr(4'd8, 8'h80);
    wr(4'd1, 8'h80);
    set_pins(8'h81);
    chk("R10 inactive", {31'd0, pwm_shutdown_o}, 32'd0);
    set_pins(8'h01);
    chk("R10 shutdown", {31'd0, pwm_shutdown_o}, 32'd1);
    wr(4'd8, 8'h00);
    #1 chk("R10 unrouted", {31'd0, pwm_shutdown_o}, 32'd0);
    wr(4'd1, 8'h00);
    set_pins(8'h00);
  endtask

  initial begin
    #(TCK * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_in = '0; spi_sel_n_i = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_output();
    t_level();
    t_edge();
    t_w1c();
    t_irq();
    t_wake();
    t_outdir();
    t_spi();
    t_pwm();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule